// File: doc/BRIEF.md
# Iterative Golay Codeword Generator

This block turns a 12-bit message into its 23-bit binary Golay (23,12,7) codeword and its 24-bit extended (24,12,8) codeword. The check bits are the remainder of a modulo-2 long division. The dividend is the message followed by eleven zero bits. The divisor is one of the two degree-11 generator polynomials, chosen by a parameter.

The division does not advance one bit per clock. Each cycle first cancels the leading one of a 12-bit working remainder with an XOR against the divisor. A leading-zero count then shifts the remainder left by several positions at once, and the vacated bits fill with zeros. A small down-counter, which starts at eleven, holds how many appended zero bits are still to be brought in. The count never moves past the dividend's end. When the counter reaches zero, one last cancellation produces the check bits. The block then raises a one-cycle completion pulse and keeps both codewords on its outputs until the next encode finishes.

A client pulses the start input with a message and waits for the completion pulse. The extended codeword is the 23-bit codeword with an overall parity bit appended.

Top module: `golay_iter_enc`

## Requirements
- R1: After an encode, code23_o[22:11] equals the message sampled with start_i, and code23_o[10:0] equals the remainder of message·X^11 divided by the generator. The generator's bit 11 is the X^11 coefficient. GEN_SEL=1 selects 101011100011 (AE3h) and GEN_SEL=0 selects 110001110101 (C75h).
- R2: With GEN_SEL=1, message A27h gives check bits 435h. code23_o is then 513C35h and code24_o is A2786Bh.
- R3: code24_o[23:1] equals code23_o and code24_o[0] is the XOR of all bits of code23_o, so the extended codeword always has even weight.
- R4: For every nonzero message, the weight of code24_o is a multiple of four and at least 8.
- R5: The all-zero message yields all-zero code23_o and code24_o.
- R6: done_o is high for exactly one cycle per accepted start. Counting the clock edge that samples start_i as edge 1, done_o rises after edge 12 at the latest.
- R7: While an encode is in progress, start_i is ignored, and changes of msg_i after the start edge have no effect on the result or its timing.
- R8: code23_o and code24_o change only in the cycle in which done_o rises, and otherwise hold their values, whatever msg_i does.
- R9: Synchronous active-high rst abandons any encode, clears done_o, code23_o and code24_o to zero, and leaves the block idle and ready for a new start.
- R10: Both generator choices produce correct codewords (R1, R3, R4) for every message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an encode of msg_i; ignored while busy |
| msg_i | input | 12 | Message to encode, sampled with start_i |
| done_o | output | 1 | One-cycle pulse when the codewords are updated |
| code23_o | output | 23 | Binary Golay codeword: message above, check bits below |
| code24_o | output | 24 | Extended codeword: code23_o followed by its parity bit |

## Verification
A wrong shift distance or a wrong counter step leaves a remainder misaligned with the divisor. This shows in code23_o[10:0] the moment done_o pulses, and usually also as an extended weight that is not a multiple of four. A counter that stops early or late moves the done_o pulse off its expected edge or past the 12-edge bound. A message register that tracks msg_i while busy corrupts the upper field of the very next codeword. Every one of the 4096 messages is encoded under both generators, so any misstep is seen no later than the completion pulse of the encode it occurs in.

// File: rtl/golay_pkg.sv
package golay_pkg;

   localparam int GOLAY_MSG_W = 12;
   localparam int GOLAY_CHK_W = 11;

   // Degree-11 factors of X^23+1, bit 11 holds the X^11 coefficient
   localparam logic [GOLAY_MSG_W-1:0] GEN_POLY_A = 12'hC75;
   localparam logic [GOLAY_MSG_W-1:0] GEN_POLY_B = 12'hAE3;

   typedef enum logic {
      ENC_IDLE = 1'b0,
      ENC_RUN  = 1'b1
   } enc_state_e;

endpackage

// File: rtl/golay_lzc.sv
// Leading-zero counter: number of zero bits above the highest one.
module golay_lzc #(
   parameter int W  = 12,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] zeros_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("golay_lzc: width must be at least 2");
      end
      if ((1 << CW) <= W) begin : g_bad_cw
         $error("golay_lzc: count width too small");
      end
   endgenerate

   // one-hot marker of the highest set bit, built per position
   logic [W-1:0] higher_set;
   logic [W-1:0] first_one;

   generate
      for (genvar i = 0; i < W; i++) begin : g_pos
         if (i == W - 1) begin : g_top
            assign higher_set[i] = 1'b0;
         end else begin : g_rest
            assign higher_set[i] = |vec_i[W-1:i+1];
         end
         assign first_one[i] = vec_i[i] & ~higher_set[i];
      end
   endgenerate

   always_comb begin
      zeros_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (first_one[i]) zeros_o = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/golay_divstep.sv
// One combinational division iteration: cancel, count, limited shift.
module golay_divstep #(
   parameter int W     = 12,
   parameter int CNT_W = 5,
   parameter int LZ_W  = $clog2(W + 1)
) (
   input  logic [W-1:0]     rem_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [W-1:0]     poly_i,
   output logic [W-1:0]     rem_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o,
   output logic [W-2:0]     chk_o
);

   generate
      if (LZ_W > CNT_W - 1) begin : g_bad_cnt
         $error("golay_divstep: counter narrower than shift count");
      end
   endgenerate

   logic [W-1:0]     cancelled;
   logic [LZ_W-1:0]  lead_zeros;
   logic [CNT_W-1:0] diff;
   logic             limit;
   logic [LZ_W-1:0]  shamt;

   // modulo-2 subtraction whenever the leading position is occupied
   assign cancelled = rem_i[W-1] ? (rem_i ^ poly_i) : rem_i;

   golay_lzc #(.W(W), .CW(LZ_W)) u_lzc (
      .vec_i   (cancelled),
      .zeros_o (lead_zeros)
   );

   // remaining-count minus skip; sign bit or zero ends the shifting
   assign diff   = cnt_i - {{(CNT_W-LZ_W){1'b0}}, lead_zeros};
   assign limit  = diff[CNT_W-1] | (diff == '0);
   assign shamt  = limit ? cnt_i[LZ_W-1:0] : lead_zeros;

   assign rem_o  = cancelled << shamt;
   assign cnt_o  = limit ? '0 : diff;
   assign last_o = (cnt_i == '0);
   assign chk_o  = cancelled[W-2:0];

endmodule

// File: rtl/golay_popcount.sv
// Ripple population count built as a generated chain of adders.
module golay_popcount #(
   parameter int W  = 23,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] weight_o,
   output logic          parity_o
);

   logic [CW-1:0] partial [0:W];

   assign partial[0] = '0;

   generate
      for (genvar i = 0; i < W; i++) begin : g_acc
         assign partial[i+1] = partial[i] + CW'(vec_i[i]);
      end
   endgenerate

   assign weight_o = partial[W];
   assign parity_o = partial[W][0];

endmodule

// File: rtl/golay_iter_enc.sv
module golay_iter_enc
   import golay_pkg::*;
#(
   parameter int GEN_SEL = 1,
   parameter int MSG_W   = GOLAY_MSG_W,
   parameter int CHK_W   = GOLAY_CHK_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start_i,
   input  logic [MSG_W-1:0]         msg_i,
   output logic                     done_o,
   output logic [MSG_W+CHK_W-1:0]   code23_o,
   output logic [MSG_W+CHK_W:0]     code24_o
);

   localparam int CODE_W = MSG_W + CHK_W;
   localparam int EXT_W  = CODE_W + 1;
   localparam int CNT_W  = $clog2(CHK_W + 1) + 1;
   localparam int LZ_W   = $clog2(MSG_W + 1);
   localparam int WGT_W  = $clog2(CODE_W + 1);

   generate
      if (MSG_W != GOLAY_MSG_W || CHK_W != GOLAY_CHK_W) begin : g_bad_geom
         $error("golay_iter_enc: geometry must be 12 message / 11 check bits");
      end
      if (GEN_SEL < 0 || GEN_SEL > 1) begin : g_bad_sel
         $error("golay_iter_enc: GEN_SEL must be 0 or 1");
      end
   endgenerate

   logic [MSG_W-1:0] poly;
   generate
      if (GEN_SEL == 0) begin : g_poly_a
         assign poly = GEN_POLY_A;
      end else begin : g_poly_b
         assign poly = GEN_POLY_B;
      end
   endgenerate

   enc_state_e       state_q;
   logic [MSG_W-1:0] msg_q;
   logic [MSG_W-1:0] rem_q;
   logic [CNT_W-1:0] cnt_q;

   // first pass takes the message straight from the port
   logic [MSG_W-1:0] step_rem;
   logic [CNT_W-1:0] step_cnt;
   assign step_rem = (state_q == ENC_IDLE) ? msg_i : rem_q;
   assign step_cnt = (state_q == ENC_IDLE) ? CNT_W'(CHK_W) : cnt_q;

   logic [MSG_W-1:0] nxt_rem;
   logic [CNT_W-1:0] nxt_cnt;
   logic             step_last;
   logic [CHK_W-1:0] step_chk;

   golay_divstep #(.W(MSG_W), .CNT_W(CNT_W), .LZ_W(LZ_W)) u_step (
      .rem_i  (step_rem),
      .cnt_i  (step_cnt),
      .poly_i (poly),
      .rem_o  (nxt_rem),
      .cnt_o  (nxt_cnt),
      .last_o (step_last),
      .chk_o  (step_chk)
   );

   logic [CODE_W-1:0] new_code;
   logic [WGT_W-1:0]  new_weight;
   logic              new_parity;
   assign new_code = {msg_q, step_chk};

   golay_popcount #(.W(CODE_W), .CW(WGT_W)) u_pop (
      .vec_i    (new_code),
      .weight_o (new_weight),
      .parity_o (new_parity)
   );

   logic finish;
   assign finish = (state_q == ENC_RUN) && step_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ENC_IDLE;
         msg_q    <= '0;
         rem_q    <= '0;
         cnt_q    <= '0;
         done_o   <= 1'b0;
         code23_o <= '0;
         code24_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ENC_IDLE: begin
               if (start_i) begin
                  msg_q   <= msg_i;
                  rem_q   <= nxt_rem;
                  cnt_q   <= nxt_cnt;
                  state_q <= ENC_RUN;
               end
            end
            ENC_RUN: begin
               if (step_last) begin
                  code23_o <= new_code;
                  code24_o <= {new_code, new_parity};
                  done_o   <= 1'b1;
                  state_q  <= ENC_IDLE;
               end else begin
                  rem_q <= nxt_rem;
                  cnt_q <= nxt_cnt;
               end
            end
            default: state_q <= ENC_IDLE;
         endcase
      end
   end

   // ---------------- checks ----------------
   logic [CNT_W-1:0] run_edges_q;
   always_ff @(posedge clk) begin
      if (rst || state_q == ENC_IDLE) run_edges_q <= '0;
      else                            run_edges_q <= run_edges_q + 1'b1;
   end

   assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q == ENC_RUN) |-> (run_edges_q < CNT_W'(CHK_W)));

   assert_cnt_sign_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q == ENC_RUN) |-> !cnt_q[CNT_W-1]);

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_final_cancel_R1: assert property (@(posedge clk) disable iff (rst)
      finish |-> (nxt_rem[MSG_W-1] == 1'b0));

   assert_msg_field_R1: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (code23_o[CODE_W-1:CHK_W] == msg_q));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!done_o && !$past(rst)) |-> ($stable(code23_o) && $stable(code24_o)));

   assert_even_weight_R3: assert property (@(posedge clk) disable iff (rst)
      ($countones(code24_o) % 2) == 0);

   assert_popcnt_R3: assert property (@(posedge clk) disable iff (rst)
      finish |-> (int'(new_weight) == $countones(new_code)));

   assert_weight_R4: assert property (@(posedge clk) disable iff (rst)
      (done_o && code23_o != '0) |->
         ((($countones(code24_o) % 4) == 0) && ($countones(code24_o) >= 8)));

   assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (done_o && msg_q == '0) |-> (code24_o == '0));

endmodule

// File: tb/tb_golay_iter_enc.sv
`timescale 1ns/1ps
module tb_golay_iter_enc;

   logic        clk = 1'b0;
   logic        rst;
   logic        start_i;
   logic [11:0] msg_i;
   logic        done_b, done_a;
   logic [22:0] c23_b, c23_a;
   logic [23:0] c24_b, c24_a;

   always #5 clk = ~clk;

   golay_iter_enc #(.GEN_SEL(1)) dut (
      .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
      .done_o(done_b), .code23_o(c23_b), .code24_o(c24_b));

   golay_iter_enc #(.GEN_SEL(0)) dut_g1 (
      .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
      .done_o(done_a), .code23_o(c23_a), .code24_o(c24_a));

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // bit-serial remainder of msg*X^11 modulo poly
   function automatic logic [10:0] ref_chk(input logic [11:0] m,
                                           input logic [11:0] poly);
      logic [10:0] r = '0;
      for (int i = 11; i >= 0; i--) begin
         logic fb = m[i] ^ r[10];
         r = {r[9:0], 1'b0};
         if (fb) r = r ^ poly[10:0];
      end
      return r;
   endfunction

   typedef struct packed {
      logic [11:0] msg;
      logic [10:0] chk_b;
      logic        known;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{12'hA27, 11'h435, 1'b1},
      '{12'h001, 11'h2E3, 1'b1},
      '{12'h000, 11'h000, 1'b1},
      '{12'hFFF, 11'h000, 1'b0},
      '{12'h800, 11'h000, 1'b0},
      '{12'h555, 11'h000, 1'b0},
      '{12'hAAA, 11'h000, 1'b0},
      '{12'h7FF, 11'h000, 1'b0}
   };

   int          lat_b, lat_a;
   logic [22:0] r23_b, r23_a;
   logic [23:0] r24_b, r24_a;
   bit          pulse_ok;

   // start an encode; glitch re-asserts start and scrambles msg_i while busy
   task automatic encode(input logic [11:0] m, input bit glitch);
      lat_b = 0; lat_a = 0; pulse_ok = 1'b1;
      @(negedge clk);
      start_i = 1'b1; msg_i = m;
      for (int n = 1; n <= 14; n++) begin
         @(negedge clk);
         if (done_b) begin
            if (lat_b != 0) pulse_ok = 1'b0;
            lat_b = n; r23_b = c23_b; r24_b = c24_b;
         end
         if (done_a) begin
            if (lat_a != 0) pulse_ok = 1'b0;
            lat_a = n; r23_a = c23_a; r24_a = c24_a;
         end
         if (n == 1) begin
            start_i = glitch;
            msg_i   = glitch ? ~m : m;
         end else begin
            start_i = 1'b0;
            msg_i   = glitch ? (m ^ 12'(n * 331)) : m;
         end
      end
   endtask

   task automatic check_codes(input logic [11:0] m);
      logic [22:0] e_b = {m, ref_chk(m, 12'hAE3)};
      logic [22:0] e_a = {m, ref_chk(m, 12'hC75)};
      chk(lat_b >= 1 && lat_b <= 12 && pulse_ok, "R6 latency/pulse", lat_b, 12);
      chk(lat_a >= 1 && lat_a <= 12, "R6 latency g1", lat_a, 12);
      chk(r23_b == e_b, "R1 code23", r23_b, e_b);
      chk(r23_a == e_a, "R10 code23 g1", r23_a, e_a);
      chk(r24_b == {r23_b, ^r23_b}, "R3 code24", r24_b, {r23_b, ^r23_b});
      chk(r24_a == {r23_a, ^r23_a}, "R3 code24 g1", r24_a, {r23_a, ^r23_a});
      if (m != '0) begin
         chk(($countones(r24_b) % 4 == 0) && ($countones(r24_b) >= 8),
             "R4 weight", $countones(r24_b), 8);
         chk(($countones(r24_a) % 4 == 0) && ($countones(r24_a) >= 8),
             "R4 weight g1", $countones(r24_a), 8);
      end
   endtask

   initial begin
      int lat_ref;
      logic [22:0] hold23;
      logic [23:0] hold24;
      bit held;

      rst = 1'b1; start_i = 1'b0; msg_i = '0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!done_b && c23_b == '0 && c24_b == '0, "R9 reset state", c24_b, 0);

      // directed: known vector
      encode(12'hA27, 1'b0);
      chk(r23_b == 23'h513C35, "R2 code23 A27", r23_b, 23'h513C35);
      chk(r24_b == 24'hA2786B, "R2 code24 A27", r24_b, 24'hA2786B);
      lat_ref = lat_b;

      // table walk
      foreach (VECS[i]) begin
         encode(VECS[i].msg, 1'b0);
         check_codes(VECS[i].msg);
         if (VECS[i].known)
            chk(r23_b[10:0] == VECS[i].chk_b, "R1 table check bits",
                r23_b[10:0], VECS[i].chk_b);
      end

      // all-zero message
      encode(12'h000, 1'b0);
      chk(r23_b == '0 && r24_b == '0 && r24_a == '0, "R5 zero codeword", r24_b, 0);

      // start and message changes while busy
      encode(12'hA27, 1'b1);
      chk(r23_b == 23'h513C35, "R7 ignored start result", r23_b, 23'h513C35);
      chk(lat_b == lat_ref && pulse_ok, "R7 ignored start timing", lat_b, lat_ref);

      // outputs hold while idle and msg_i moves
      hold23 = c23_b; hold24 = c24_b; held = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         msg_i = 12'(k * 97);
         if (done_b || c23_b != hold23 || c24_b != hold24) held = 1'b0;
      end
      chk(held, "R8 outputs hold", c23_b, hold23);

      // reset in the middle of an encode
      @(negedge clk);
      start_i = 1'b1; msg_i = 12'hFFF;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      held = 1'b1;
      for (int k = 0; k < 15; k++) begin
         @(negedge clk);
         if (done_b || done_a) held = 1'b0;
      end
      chk(held && c23_b == '0 && c24_b == '0, "R9 abort by reset", c24_b, 0);
      encode(12'h123, 1'b0);
      check_codes(12'h123);

      // every message, both generators
      for (int m = 0; m < 4096; m++) begin
         encode(12'(m), 1'b0);
         check_codes(12'(m));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule